// File: doc/BRIEF.md
# Weighted Singleton Centroid Defuzzifier

This block turns the outcome of fuzzy rule evaluation into crisp output values. Each fired rule arrives as a beat on a valid/ready stream that carries a 4-bit rule weight and the 8-bit position of the singleton consequent the rule points at. Two accumulators run side by side. One sums weight times position and the other sums the weights. A sequential restoring divider then forms the weighted average, which is the centroid of the weighted singletons.

Rules arrive grouped by output variable. A flag on the last rule of a variable closes that group. A second flag on the same beat marks the variable as the final one of the control cycle. Results are numbered with a 2-bit identifier in order of arrival, and the numbering restarts after each cycle. Each result is announced by a strobe pulse. A hold input lets the block finish the division while it withholds the result from the output. This keeps a slow consumer in step with the block.

Top module: `defz_centroid`

## Requirements
- R1: The presented value equals floor(Σ weight·position / Σ weight), taken over the rules of one output variable, with an 8-bit result.
- R2: When the weight sum of a variable is zero, the result is 0 and `y_zero_err` is 1 for that result. Otherwise `y_zero_err` is 0.
- R3: The accumulator widths are derived from the rule limit (default 256). A variable with that many full-scale rules (weight 15, position 255) produces 255, with no wrap-around.
- R4: `y_id` is 0 for the first variable after reset and for the first variable after a cycle-ending variable. It rises by one for each later variable.
- R5: `y_strobe` stays high for 5 clocks for an ordinary variable and for 1 clock for a variable accepted with `rule_end_cycle`=1. `y_data`, `y_id` and `y_zero_err` stay stable while it is high.
- R6: While `hold_in` is 1, `y_strobe` does not rise and `y_data` keeps its previous value. After `hold_in` returns to 0, the held result appears.
- R7: `rule_ready` is 0 from the clock after the closing rule of a variable is accepted until the strobe for that variable ends. Beats offered in that time are ignored.
- R8: After reset, `y_strobe` and `y_zero_err` are 0, `y_data` and `y_id` are 0, and `rule_ready` is 1.
- R9: With `hold_in` low, `y_strobe` rises 23 clocks after the edge that accepts the closing rule. This is the number of dividend bits (20) plus 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_valid | input | 1 | A rule beat is offered |
| rule_ready | output | 1 | The block accepts rule beats |
| rule_weight | input | 4 | Rule weight |
| rule_pos | input | 8 | Position of the singleton consequent |
| rule_end_var | input | 1 | The beat is the last rule of the current variable |
| rule_end_cycle | input | 1 | With rule_end_var: the variable is the final one of the cycle |
| hold_in | input | 1 | Withhold presentation of the next result |
| y_data | output | 8 | Crisp result |
| y_id | output | 2 | Identifier of the variable being presented |
| y_zero_err | output | 1 | The weight sum was zero for this result |
| y_strobe | output | 1 | Result valid pulse |

## Verification
The main sweep covers two-rule variables over every pair of weights 0..15, using three position pairs: extremes, mid-range values, and two adjacent high values. This separates truncation from rounding, catches swapped numerator and denominator paths, and covers the zero-sum case. Runs of 256 full-scale rules show whether the accumulators wrap. Single-rule, uniform-position and mixed multi-rule variables are grouped into cycles of different lengths, which checks identifier numbering and the short final strobe. Held results, with beats offered while the hold is in place, show that neither the output nor the accumulators are disturbed.

// File: rtl/defz_pkg.sv
package defz_pkg;
   typedef enum logic [1:0] {
      CT_ACC  = 2'd0,
      CT_LOAD = 2'd1,
      CT_DIV  = 2'd2,
      CT_SHOW = 2'd3
   } ctl_state_t;

   typedef enum logic [1:0] {
      PR_IDLE = 2'd0,
      PR_HOLD = 2'd1,
      PR_STB  = 2'd2
   } pres_state_t;
endpackage

// File: rtl/defz_accum.sv
module defz_accum #(
   parameter int W_W   = 4,
   parameter int X_W   = 8,
   parameter int NUM_W = 20,
   parameter int DEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [W_W-1:0]   w,
   input  logic [X_W-1:0]   x,
   output logic [NUM_W-1:0] num,
   output logic [DEN_W-1:0] den
);
   logic [NUM_W-1:0] prod;

   generate
      if (W_W == 1) begin : g_gate
         assign prod = w[0] ? NUM_W'(x) : '0;
      end else begin : g_mult
         assign prod = NUM_W'(w) * NUM_W'(x);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         num <= '0;
         den <= '0;
      end else if (add) begin
         num <= num + prod;
         den <= den + DEN_W'(w);
      end
   end
endmodule

// File: rtl/defz_divider.sv
module defz_divider #(
   parameter int NUM_W = 20,
   parameter int DEN_W = 12,
   parameter int Q_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [Q_W-1:0]   q_out,
   output logic             zero,
   output logic             done
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem;
   logic [NUM_W-1:0] dvd;
   logic [DEN_W-1:0] dsr;
   logic [NUM_W-1:0] quo;
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic [DEN_W:0]   rem_sh;
   logic [DEN_W:0]   rem_sub;
   logic             fits;

   assign rem_sh  = {rem, dvd[NUM_W-1]};
   assign rem_sub = rem_sh - {1'b0, dsr};
   assign fits    = rem_sh >= {1'b0, dsr};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem  <= '0;
         dvd  <= '0;
         dsr  <= '0;
         quo  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         zero <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         rem  <= '0;
         dvd  <= num;
         dsr  <= den;
         quo  <= '0;
         cnt  <= CNT_W'(NUM_W);
         busy <= 1'b1;
         zero <= (den == '0);
         done <= 1'b0;
      end else if (busy) begin
         rem  <= fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
         dvd  <= {dvd[NUM_W-2:0], 1'b0};
         quo  <= {quo[NUM_W-2:0], fits};
         cnt  <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

   generate
      if (NUM_W > Q_W) begin : g_sat
         assign q_out = zero ? '0 : ((|quo[NUM_W-1:Q_W]) ? '1 : quo[Q_W-1:0]);
      end else begin : g_nosat
         assign q_out = zero ? '0 : Q_W'(quo);
      end
   endgenerate
endmodule

// File: rtl/defz_present.sv
module defz_present
   import defz_pkg::*;
#(
   parameter int Y_W          = 8,
   parameter int ID_W         = 2,
   parameter int STB_LEN      = 5,
   parameter int STB_LAST_LEN = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [Y_W-1:0]  q_in,
   input  logic [ID_W-1:0] id_in,
   input  logic            err_in,
   input  logic            last_in,
   input  logic            hold_in,
   output logic [Y_W-1:0]  y_data,
   output logic [ID_W-1:0] y_id,
   output logic            y_err,
   output logic            y_strobe,
   output logic            done
);
   localparam int CW = $clog2(STB_LEN + 1);

   pres_state_t     st;
   logic [CW-1:0]   cnt;
   logic [Y_W-1:0]  h_q;
   logic [ID_W-1:0] h_id;
   logic            h_err;
   logic            h_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= PR_IDLE;
         cnt    <= '0;
         h_q    <= '0;
         h_id   <= '0;
         h_err  <= 1'b0;
         h_last <= 1'b0;
         y_data <= '0;
         y_id   <= '0;
         y_err  <= 1'b0;
      end else begin
         case (st)
            PR_IDLE: if (go) begin
               h_q    <= q_in;
               h_id   <= id_in;
               h_err  <= err_in;
               h_last <= last_in;
               st     <= PR_HOLD;
            end
            PR_HOLD: if (!hold_in) begin
               y_data <= h_q;
               y_id   <= h_id;
               y_err  <= h_err;
               cnt    <= h_last ? CW'(STB_LAST_LEN - 1) : CW'(STB_LEN - 1);
               st     <= PR_STB;
            end
            PR_STB: begin
               if (cnt == '0) st <= PR_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= PR_IDLE;
         endcase
      end
   end

   assign y_strobe = (st == PR_STB);
   assign done     = (st == PR_STB) && (cnt == '0);
endmodule

// File: rtl/defz_centroid.sv
module defz_centroid
   import defz_pkg::*;
#(
   parameter int W_W          = 4,
   parameter int X_W          = 8,
   parameter int ID_W         = 2,
   parameter int MAX_RULES    = 256,
   parameter int STB_LEN      = 5,
   parameter int STB_LAST_LEN = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rule_valid,
   output logic            rule_ready,
   input  logic [W_W-1:0]  rule_weight,
   input  logic [X_W-1:0]  rule_pos,
   input  logic            rule_end_var,
   input  logic            rule_end_cycle,
   input  logic            hold_in,
   output logic [X_W-1:0]  y_data,
   output logic [ID_W-1:0] y_id,
   output logic            y_zero_err,
   output logic            y_strobe
);
   localparam int RC_W  = $clog2(MAX_RULES);
   localparam int NUM_W = W_W + X_W + RC_W;
   localparam int DEN_W = W_W + RC_W;

   generate
      if (W_W < 1 || X_W < 2) begin : g_bad_width
         $error("defz_centroid: weight or position width too small");
      end
      if (STB_LAST_LEN < 1 || STB_LEN < STB_LAST_LEN) begin : g_bad_stb
         $error("defz_centroid: strobe lengths out of range");
      end
      if (MAX_RULES < 2) begin : g_bad_rules
         $error("defz_centroid: rule limit too small");
      end
   endgenerate

   ctl_state_t      st;
   logic [ID_W-1:0] var_id;
   logic [ID_W-1:0] cur_id;
   logic            cur_last;
   logic            accept;
   logic [NUM_W-1:0] acc_num;
   logic [DEN_W-1:0] acc_den;
   logic [X_W-1:0]  div_q;
   logic            div_zero;
   logic            div_done;
   logic            pres_done;

   assign rule_ready = (st == CT_ACC);
   assign accept     = rule_valid && rule_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= CT_ACC;
         var_id   <= '0;
         cur_id   <= '0;
         cur_last <= 1'b0;
      end else begin
         case (st)
            CT_ACC: if (accept && rule_end_var) begin
               cur_id   <= var_id;
               cur_last <= rule_end_cycle;
               var_id   <= rule_end_cycle ? '0 : var_id + 1'b1;
               st       <= CT_LOAD;
            end
            CT_LOAD: st <= CT_DIV;
            CT_DIV:  if (div_done)  st <= CT_SHOW;
            CT_SHOW: if (pres_done) st <= CT_ACC;
            default: st <= CT_ACC;
         endcase
      end
   end

   defz_accum #(.W_W(W_W), .X_W(X_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_accum (
      .clk (clk), .rst_n (rst_n), .clr (st == CT_LOAD), .add (accept),
      .w (rule_weight), .x (rule_pos), .num (acc_num), .den (acc_den)
   );

   defz_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(X_W)) u_div (
      .clk (clk), .rst_n (rst_n), .start (st == CT_LOAD),
      .num (acc_num), .den (acc_den), .q_out (div_q), .zero (div_zero), .done (div_done)
   );

   defz_present #(.Y_W(X_W), .ID_W(ID_W), .STB_LEN(STB_LEN), .STB_LAST_LEN(STB_LAST_LEN)) u_pres (
      .clk (clk), .rst_n (rst_n), .go (div_done), .q_in (div_q), .id_in (cur_id),
      .err_in (div_zero), .last_in (cur_last), .hold_in (hold_in),
      .y_data (y_data), .y_id (y_id), .y_err (y_zero_err), .y_strobe (y_strobe), .done (pres_done)
   );
endmodule

// File: rtl/defz_centroid_chk.sv
module defz_centroid_chk #(
   parameter int X_W     = 8,
   parameter int ID_W    = 2,
   parameter int STB_LEN = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rule_ready,
   input logic            hold_in,
   input logic [X_W-1:0]  y_data,
   input logic [ID_W-1:0] y_id,
   input logic            y_zero_err,
   input logic            y_strobe
);
   logic [7:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)        run_len <= '0;
      else if (y_strobe) run_len <= run_len + 8'd1;
      else               run_len <= '0;
   end

   // R5: a result does not change while its strobe is high
   a_r5_stable_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (y_strobe && $past(y_strobe)) |-> ($stable(y_data) && $stable(y_id) && $stable(y_zero_err)));

   // R5: the strobe is never longer than the ordinary length
   a_r5_max_width: assert property (@(posedge clk) disable iff (!rst_n)
      y_strobe |-> (run_len < 8'(STB_LEN)));

   // R6: no new strobe starts while the hold input is high
   a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_in && !y_strobe) |=> !y_strobe);

   // R2: a zero weight sum gives a zero result
   a_r2_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
      (y_strobe && y_zero_err) |-> (y_data == '0));

   // R7: no rule is taken while a result is presented
   a_r7_no_ready_when_presenting: assert property (@(posedge clk) disable iff (!rst_n)
      y_strobe |-> !rule_ready);
endmodule

bind defz_centroid defz_centroid_chk #(.X_W(X_W), .ID_W(ID_W), .STB_LEN(STB_LEN)) u_chk (
   .clk (clk), .rst_n (rst_n), .rule_ready (rule_ready), .hold_in (hold_in),
   .y_data (y_data), .y_id (y_id), .y_zero_err (y_zero_err), .y_strobe (y_strobe)
);

// File: tb/defz_centroid_bench.sv
module defz_centroid_bench;
   localparam int LAT = 23;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rule_valid = 1'b0;
   logic       rule_ready;
   logic [3:0] rule_weight = '0;
   logic [7:0] rule_pos = '0;
   logic       rule_end_var = 1'b0;
   logic       rule_end_cycle = 1'b0;
   logic       hold_in = 1'b0;
   logic [7:0] y_data;
   logic [1:0] y_id;
   logic       y_zero_err;
   logic       y_strobe;

   int checks = 0;
   int fails = 0;
   int exp_id = 0;
   int prev_y = 0;
   bit finished = 1'b0;
   int tw[256];
   int tx[256];

   always #2.5 clk = ~clk;

   defz_centroid u_defz_centroid (
      .clk (clk), .rst_n (rst_n), .rule_valid (rule_valid), .rule_ready (rule_ready),
      .rule_weight (rule_weight), .rule_pos (rule_pos), .rule_end_var (rule_end_var),
      .rule_end_cycle (rule_end_cycle), .hold_in (hold_in), .y_data (y_data),
      .y_id (y_id), .y_zero_err (y_zero_err), .y_strobe (y_strobe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic run_var(input int n, input bit endc, input int hold_cyc);
      int num = 0;
      int den = 0;
      int expv;
      int c;
      int wdt;
      bit rose;
      for (int i = 0; i < n; i++) begin
         num += tw[i] * tx[i];
         den += tw[i];
      end
      expv = (den == 0) ? 0 : num / den;
      for (int i = 0; i < n; i++) begin
         rule_valid     = 1'b1;
         rule_weight    = 4'(tw[i]);
         rule_pos       = 8'(tx[i]);
         rule_end_var   = (i == n - 1);
         rule_end_cycle = endc && (i == n - 1);
         if (i == n - 1 && hold_cyc > 0) hold_in = 1'b1;
         while (!rule_ready) @(negedge clk);
         @(negedge clk);
      end
      rule_valid = 1'b0;
      rule_end_var = 1'b0;
      rule_end_cycle = 1'b0;
      if (hold_cyc > 0) begin
         rose = 1'b0;
         for (int k = 0; k < hold_cyc; k++) begin
            rule_valid  = 1'b1;        // R7: offered beats must be ignored
            rule_weight = 4'd15;
            rule_pos    = 8'(k * 37);
            if (y_strobe) rose = 1'b1;
            @(negedge clk);
         end
         rule_valid = 1'b0;
         chk(!rose, "R6 strobe during hold", int'(rose), 0);
         chk(int'(y_data) == prev_y, "R6 data kept during hold", int'(y_data), prev_y);
         hold_in = 1'b0;
      end
      c = 0;
      while (!y_strobe && c < 300) begin
         @(negedge clk);
         c++;
      end
      if (hold_cyc == 0) chk(c == LAT, "R9 latency", c, LAT);
      chk(int'(y_data) == expv, "R1 result", int'(y_data), expv);
      chk(int'(y_zero_err) == int'(den == 0), "R2 zero flag", int'(y_zero_err), int'(den == 0));
      chk(int'(y_id) == exp_id, "R4 identifier", int'(y_id), exp_id);
      wdt = 0;
      while (y_strobe && wdt < 20) begin
         wdt++;
         @(negedge clk);
      end
      chk(wdt == (endc ? 1 : 5), "R5 strobe width", wdt, endc ? 1 : 5);
      prev_y = expv;
      exp_id = endc ? 0 : exp_id + 1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      int px[3];
      int py[3];
      int k;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk(y_strobe == 1'b0, "R8 strobe after reset", int'(y_strobe), 0);
      chk(rule_ready == 1'b1, "R8 ready after reset", int'(rule_ready), 1);
      chk(y_data == 8'd0, "R8 data after reset", int'(y_data), 0);
      chk(y_id == 2'd0, "R8 id after reset", int'(y_id), 0);
      chk(y_zero_err == 1'b0, "R8 flag after reset", int'(y_zero_err), 0);

      // R1 single rule gives its position
      tw[0] = 7; tx[0] = 201;
      run_var(1, 1'b0, 0);
      // R2 all weights zero
      tw[0] = 0; tx[0] = 90; tw[1] = 0; tx[1] = 40;
      run_var(2, 1'b0, 0);
      // R1 mixed multi-rule, R6 with hold and ignored beats (R7)
      for (int i = 0; i < 6; i++) begin tw[i] = i * 3 % 16; tx[i] = i * 47 + 3; end
      run_var(6, 1'b1, 40);
      // R4 cycle of three, restart afterwards
      tw[0] = 15; tx[0] = 0; tw[1] = 1; tx[1] = 255;
      run_var(2, 1'b0, 0);
      run_var(2, 1'b0, 35);
      run_var(2, 1'b1, 0);
      tw[0] = 5; tx[0] = 128; tw[1] = 5; tx[1] = 129;
      run_var(2, 1'b0, 0);
      run_var(2, 1'b1, 0);

      // R3 full-scale runs
      for (int i = 0; i < 256; i++) begin tw[i] = 15; tx[i] = 255; end
      run_var(256, 1'b0, 0);
      for (int i = 0; i < 256; i++) begin tw[i] = 15; tx[i] = (i % 2 == 0) ? 0 : 255; end
      run_var(256, 1'b1, 0);

      // R1/R2 sweep of two-rule variables, grouped in cycles of four
      px[0] = 0;  py[0] = 255;
      px[1] = 17; py[1] = 200;
      px[2] = 255; py[2] = 254;
      k = 0;
      for (int p = 0; p < 3; p++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               tw[0] = a; tx[0] = px[p];
               tw[1] = b; tx[1] = py[p];
               run_var(2, (k % 4) == 3, 0);
               k++;
            end
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule